// File: doc/BRIEF.md
# Floating-Point Denormal and NaN Mode Filter

This block wraps a single-precision floating-point datapath and enforces the mode rules held in a 32-bit control word. On the way in, it looks at two operands and an operation class. It can zero subnormal operands and replace NaN operands with a canonical quiet NaN before they reach the arithmetic core. On the way out, it takes the core's rounded result together with a pre-rounding "tiny" indication. It can zero tiny results and substitute the canonical NaN for any NaN outcome.

Only the arithmetic class is affected. Copy, absolute-value and negate operations pass operands and results through untouched, so NaN payloads and subnormal values survive them. The filtering path is purely combinational and adds no cycles. Two sticky status flags are registered: one records input flushes and one records result flushes. A fast-mode output reports when both modes are on and every exception trap is disabled.

Top module: `fpmode_filter`

## Requirements
- R1: With control bit 24 set and op_class 2'b00 (arithmetic), an operand whose exponent field is zero and whose fraction is non-zero leaves the block as a zero of the same sign. Zeros, normals and infinities are unchanged.
- R2: For op_class 2'b01 (copy), 2'b10 (absolute) and 2'b11 (negate), filt_a, filt_b and filt_res equal opnd_a, opnd_b and core_res bit for bit, whatever the control word holds.
- R3: With control bit 25 set and op_class 2'b00, an operand with an all-ones exponent and a non-zero fraction leaves the block as 32'h7FC00000.
- R4: With control bit 25 set and op_class 2'b00, filt_res is 32'h7FC00000 whenever either operand or core_res is a NaN.
- R5: With control bit 24 set, op_class 2'b00 and core_tiny high, filt_res is a zero carrying core_res bit 31, unless R4 applies.
- R6: With control bits 24 and 25 both clear, every output value equals its input.
- R7: flag_in_dnorm becomes 1 at the clock edge where stat_upd is high and an R1 flush happens on either operand. It then stays 1 until it is cleared.
- R8: flag_uflow becomes 1 at the clock edge where stat_upd is high and an R5 result flush happens. It then stays 1 until it is cleared.
- R9: A clock edge with stat_clr high clears both flags. If stat_upd is also high in that cycle, that cycle's flush events still set their flags.
- R10: fast_mode is 1 exactly when control bits 24 and 25 are both 1 and bits 15 and 12 to 8 are all 0.
- R11: After reset, both flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for the flags |
| ctrl_word | input | 32 | Control word: bit 24 flush, bit 25 default NaN, bits 15 and 12:8 trap enables |
| op_class | input | 2 | 00 arithmetic, 01 copy, 10 absolute, 11 negate |
| opnd_a | input | 32 | First operand, single precision |
| opnd_b | input | 32 | Second operand, single precision |
| core_res | input | 32 | Rounded result from the arithmetic core |
| core_tiny | input | 1 | Core result below minimum normal magnitude before rounding |
| stat_upd | input | 1 | Operation valid; folds this cycle's flush events into the flags |
| stat_clr | input | 1 | Status write that clears both flags |
| filt_a | output | 32 | Filtered first operand |
| filt_b | output | 32 | Filtered second operand |
| filt_res | output | 32 | Filtered result |
| fast_mode | output | 1 | Fast mode indication |
| flag_in_dnorm | output | 1 | Sticky input-flush flag |
| flag_uflow | output | 1 | Sticky result-flush flag |

## Verification
The only state in the block is the two sticky flags. A wrong flag shows at the port one edge after the update or clear that caused it, and it stays wrong until the next clear, so every random step checks both flags right after its edge. Errors in the combinational path have no delay. A misdecoded operation class or mode bit alters filt_a, filt_b or filt_res in the same cycle. The random mix therefore deliberately biases operands toward subnormals, NaNs, zeros and infinities under all four operation classes.

// File: rtl/fpmf_pkg.sv
package fpmf_pkg;

    typedef enum logic [1:0] {
        OPC_ARITH = 2'b00,
        OPC_COPY  = 2'b01,
        OPC_ABS   = 2'b10,
        OPC_NEG   = 2'b11
    } op_class_e;

    localparam int NUM_OPS   = 2;
    localparam int FLAG_IDN  = 0;
    localparam int FLAG_UFL  = 1;
    localparam int NUM_FLAGS = 2;

endpackage

// File: rtl/fpmf_operand_filter.sv
module fpmf_operand_filter #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opnd_i,
    input  logic                  arith_i,
    input  logic                  flush_en_i,
    input  logic                  dnan_en_i,
    output logic [EXP_W+FRAC_W:0] opnd_o,
    output logic                  flushed_o,
    output logic                  nan_o
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              is_sub;

    assign exp_f  = opnd_i[W-2 -: EXP_W];
    assign frac_f = opnd_i[FRAC_W-1:0];
    assign is_sub = (exp_f == '0) && (frac_f != '0);
    assign nan_o  = (exp_f == '1) && (frac_f != '0);

    always_comb begin
        opnd_o    = opnd_i;
        flushed_o = 1'b0;
        if (arith_i) begin
            if (dnan_en_i && nan_o) begin
                opnd_o = CANON_NAN;
            end else if (flush_en_i && is_sub) begin
                opnd_o    = {opnd_i[W-1], {(W-1){1'b0}}};
                flushed_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpmf_result_filter.sv
module fpmf_result_filter #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] res_i,
    input  logic                  tiny_i,
    input  logic                  any_in_nan_i,
    input  logic                  arith_i,
    input  logic                  flush_en_i,
    input  logic                  dnan_en_i,
    output logic [EXP_W+FRAC_W:0] res_o,
    output logic                  flushed_o
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic res_nan;
    assign res_nan = (res_i[W-2 -: EXP_W] == '1) && (res_i[FRAC_W-1:0] != '0);

    always_comb begin
        res_o     = res_i;
        flushed_o = 1'b0;
        if (arith_i) begin
            if (dnan_en_i && (res_nan || any_in_nan_i)) begin
                res_o = CANON_NAN;
            end else if (flush_en_i && tiny_i) begin
                res_o     = {res_i[W-1], {(W-1){1'b0}}};
                flushed_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpmf_sticky_flags.sv
module fpmf_sticky_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_i,
    input  logic         clr_i,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] kept;
    logic [N-1:0] flags_nxt;

    always_comb begin
        kept      = clr_i ? '0 : flags_o;
        flags_nxt = kept | (upd_i ? evt_i : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else begin
            flags_o <= flags_nxt;
        end
    end
endmodule

// File: rtl/fpmode_filter.sv
module fpmode_filter #(
    parameter int                EXP_W     = 8,
    parameter int                FRAC_W    = 23,
    parameter int                CTRL_W    = 32,
    parameter int                FZ_BIT    = 24,
    parameter int                DN_BIT    = 25,
    parameter logic [CTRL_W-1:0] TRAP_MASK = 32'h0000_9F00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CTRL_W-1:0]     ctrl_word,
    input  logic [1:0]            op_class,
    input  logic [EXP_W+FRAC_W:0] opnd_a,
    input  logic [EXP_W+FRAC_W:0] opnd_b,
    input  logic [EXP_W+FRAC_W:0] core_res,
    input  logic                  core_tiny,
    input  logic                  stat_upd,
    input  logic                  stat_clr,
    output logic [EXP_W+FRAC_W:0] filt_a,
    output logic [EXP_W+FRAC_W:0] filt_b,
    output logic [EXP_W+FRAC_W:0] filt_res,
    output logic                  fast_mode,
    output logic                  flag_in_dnorm,
    output logic                  flag_uflow
);
    import fpmf_pkg::*;

    localparam int W = 1 + EXP_W + FRAC_W;

    op_class_e                cls;
    logic                     arith;
    logic                     flush_en;
    logic                     dnan_en;
    logic [W-1:0]             opnd_in  [NUM_OPS];
    logic [W-1:0]             opnd_out [NUM_OPS];
    logic [NUM_OPS-1:0]       opnd_flushed;
    logic [NUM_OPS-1:0]       opnd_nan;
    logic                     res_flushed;
    logic [NUM_FLAGS-1:0]     evt;
    logic [NUM_FLAGS-1:0]     flags;

    assign cls      = op_class_e'(op_class);
    assign flush_en = ctrl_word[FZ_BIT];
    assign dnan_en  = ctrl_word[DN_BIT];

    always_comb begin
        arith = 1'b0;
        unique case (cls)
            OPC_ARITH:                 arith = 1'b1;
            OPC_COPY, OPC_ABS, OPC_NEG: arith = 1'b0;
        endcase
    end

    assign fast_mode = flush_en && dnan_en && ((ctrl_word & TRAP_MASK) == '0);

    assign opnd_in[0] = opnd_a;
    assign opnd_in[1] = opnd_b;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_opnd
        fpmf_operand_filter #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_opf (
            .opnd_i     (opnd_in[i]),
            .arith_i    (arith),
            .flush_en_i (flush_en),
            .dnan_en_i  (dnan_en),
            .opnd_o     (opnd_out[i]),
            .flushed_o  (opnd_flushed[i]),
            .nan_o      (opnd_nan[i])
        );
    end

    assign filt_a = opnd_out[0];
    assign filt_b = opnd_out[1];

    fpmf_result_filter #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_resf (
        .res_i        (core_res),
        .tiny_i       (core_tiny),
        .any_in_nan_i (|opnd_nan),
        .arith_i      (arith),
        .flush_en_i   (flush_en),
        .dnan_en_i    (dnan_en),
        .res_o        (filt_res),
        .flushed_o    (res_flushed)
    );

    assign evt[FLAG_IDN] = |opnd_flushed;
    assign evt[FLAG_UFL] = res_flushed;

    fpmf_sticky_flags #(
        .N (NUM_FLAGS)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_i   (stat_upd),
        .clr_i   (stat_clr),
        .evt_i   (evt),
        .flags_o (flags)
    );

    assign flag_in_dnorm = flags[FLAG_IDN];
    assign flag_uflow    = flags[FLAG_UFL];
endmodule

// File: rtl/fpmode_filter_chk.sv
module fpmode_filter_chk #(
    parameter int                FZ_BIT    = 24,
    parameter int                DN_BIT    = 25,
    parameter logic [31:0]       TRAP_MASK = 32'h0000_9F00
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctrl_word,
    input logic [1:0]  op_class,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [31:0] core_res,
    input logic        core_tiny,
    input logic        stat_upd,
    input logic        stat_clr,
    input logic [31:0] filt_a,
    input logic [31:0] filt_b,
    input logic [31:0] filt_res,
    input logic        fast_mode,
    input logic        flag_in_dnorm,
    input logic        flag_uflow
);
    logic a_nan, b_nan, r_nan, arith;
    assign a_nan = (opnd_a[30:23] == 8'hFF) && (opnd_a[22:0] != 0);
    assign b_nan = (opnd_b[30:23] == 8'hFF) && (opnd_b[22:0] != 0);
    assign r_nan = (core_res[30:23] == 8'hFF) && (core_res[22:0] != 0);
    assign arith = (op_class == 2'b00);

    // R2
    mover_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arith |-> (filt_a == opnd_a && filt_b == opnd_b && filt_res == core_res));

    // R4
    dnan_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[DN_BIT] && arith && (a_nan || b_nan || r_nan)) |-> filt_res == 32'h7FC0_0000);

    // R5
    tiny_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[FZ_BIT] && !ctrl_word[DN_BIT] && arith && core_tiny)
            |-> (filt_res[30:0] == 31'd0 && filt_res[31] == core_res[31]));

    // R7
    idn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_in_dnorm && !stat_clr) |=> flag_in_dnorm);

    // R8
    ufl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_uflow && !stat_clr) |=> flag_uflow);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !stat_upd) |=> (!flag_in_dnorm && !flag_uflow));

    // R10
    fast_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_mode |-> (ctrl_word[FZ_BIT] && ctrl_word[DN_BIT] && ((ctrl_word & TRAP_MASK) == 0)));
endmodule

bind fpmode_filter fpmode_filter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_word     (ctrl_word),
    .op_class      (op_class),
    .opnd_a        (opnd_a),
    .opnd_b        (opnd_b),
    .core_res      (core_res),
    .core_tiny     (core_tiny),
    .stat_upd      (stat_upd),
    .stat_clr      (stat_clr),
    .filt_a        (filt_a),
    .filt_b        (filt_b),
    .filt_res      (filt_res),
    .fast_mode     (fast_mode),
    .flag_in_dnorm (flag_in_dnorm),
    .flag_uflow    (flag_uflow)
);

// File: tb/fpmode_filter_test.sv
`timescale 1ns/1ps
module fpmode_filter_test;
    localparam logic [31:0] DNAN = 32'h7FC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [1:0]  op_class = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0, core_res = '0;
    logic        core_tiny = 1'b0, stat_upd = 1'b0, stat_clr = 1'b0;
    logic [31:0] filt_a, filt_b, filt_res;
    logic        fast_mode, flag_in_dnorm, flag_uflow;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic exp_idn = 0, exp_ufl = 0;

    always #5 clk = ~clk;

    fpmode_filter uut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .op_class(op_class),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .core_res(core_res), .core_tiny(core_tiny),
        .stat_upd(stat_upd), .stat_clr(stat_clr), .filt_a(filt_a), .filt_b(filt_b),
        .filt_res(filt_res), .fast_mode(fast_mode), .flag_in_dnorm(flag_in_dnorm),
        .flag_uflow(flag_uflow)
    );

    function automatic logic is_sub(logic [31:0] x);
        return (x[30:23] == 8'h00) && (x[22:0] != 0);
    endfunction
    function automatic logic is_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 0);
    endfunction
    function automatic logic [31:0] want_opnd(logic [31:0] x, logic [31:0] c, logic [1:0] k);
        if (k != 2'b00) return x;
        if (c[25] && is_nan(x)) return DNAN;
        if (c[24] && is_sub(x)) return {x[31], 31'd0};
        return x;
    endfunction
    function automatic logic dn_hit(logic [31:0] a, logic [31:0] b, logic [31:0] r, logic [31:0] c, logic [1:0] k);
        return (k == 2'b00) && c[25] && (is_nan(a) || is_nan(b) || is_nan(r));
    endfunction
    function automatic logic [31:0] want_res(logic [31:0] a, logic [31:0] b, logic [31:0] r,
                                             logic t, logic [31:0] c, logic [1:0] k);
        if (k != 2'b00) return r;
        if (dn_hit(a, b, r, c, k)) return DNAN;
        if (c[24] && t) return {r[31], 31'd0};
        return r;
    endfunction
    function automatic logic want_fast(logic [31:0] c);
        return c[24] && c[25] && !c[15] && (c[12:8] == 5'd0);
    endfunction
    function automatic string tag_of(logic [31:0] c, logic [1:0] k);
        if (k != 2'b00) return "R2";
        if (c[25]) return "R3/R4";
        if (c[24]) return "R1/R5";
        return "R6";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] gen_val();
        logic [31:0] r = $urandom;
        unique case ($urandom_range(0, 5))
            0: return {r[31], 8'h00, (r[22:0] == 0) ? 23'd1 : r[22:0]};
            1: return {r[31], 8'hFF, (r[22:0] == 0) ? 23'h400 : r[22:0]};
            2: return {r[31], 31'd0};
            3: return {r[31], 8'hFF, 23'd0};
            default: return {r[31], (r[30:23] == 8'hFF || r[30:23] == 8'h00) ? 8'h40 : r[30:23], r[22:0]};
        endcase
    endfunction

    task automatic step(logic [31:0] a, logic [31:0] b, logic [31:0] r, logic t,
                        logic [1:0] k, logic [31:0] c, logic upd, logic clr);
        logic ev_i, ev_u;
        string tg;
        @(negedge clk);
        opnd_a = a; opnd_b = b; core_res = r; core_tiny = t;
        op_class = k; ctrl_word = c; stat_upd = upd; stat_clr = clr;
        #1;
        tg = tag_of(c, k);
        chk({tg, " filt_a"}, filt_a, want_opnd(a, c, k));
        chk({tg, " filt_b"}, filt_b, want_opnd(b, c, k));
        chk({tg, " filt_res"}, filt_res, want_res(a, b, r, t, c, k));
        chk("R10 fast_mode", {31'd0, fast_mode}, {31'd0, want_fast(c)});
        ev_i = (k == 2'b00) && c[24] && (is_sub(a) || is_sub(b));
        ev_u = (k == 2'b00) && c[24] && t && !dn_hit(a, b, r, c, k);
        exp_idn = (clr ? 1'b0 : exp_idn) | (upd & ev_i);
        exp_ufl = (clr ? 1'b0 : exp_ufl) | (upd & ev_u);
        @(posedge clk);
        #1;
        chk("R7/R9 flag_in_dnorm", {31'd0, flag_in_dnorm}, {31'd0, exp_idn});
        chk("R8/R9 flag_uflow", {31'd0, flag_uflow}, {31'd0, exp_ufl});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 flag_in_dnorm after reset", {31'd0, flag_in_dnorm}, 32'd0);
        chk("R11 flag_uflow after reset", {31'd0, flag_uflow}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 directed: negative subnormal flushed, flag sets
        step(32'h8000_0001, 32'h3F80_0000, 32'h3F80_0000, 0, 2'b00, 32'h0100_0000, 1, 0);
        // R2 directed: negate class keeps subnormal and NaN payload
        step(32'h0000_0005, 32'h7F80_1234, 32'h7F80_1234, 1, 2'b11, 32'h0300_0000, 1, 0);
        // R3/R4 directed: NaN payload replaced
        step(32'hFFC0_0ABC, 32'h4000_0000, 32'h4040_0000, 0, 2'b00, 32'h0200_0000, 1, 0);
        // R5/R8 directed: tiny result flushed
        step(32'h0080_0000, 32'h0080_0000, 32'h8080_0000, 1, 2'b00, 32'h0100_0000, 1, 0);
        // R9: clear with no update
        step(32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 0, 2'b00, 32'h0, 0, 1);
        // R9: clear and update in same cycle keeps new event
        step(32'h0000_0010, 32'h3F80_0000, 32'h0000_0001, 1, 2'b00, 32'h0100_0000, 1, 1);
        // R10 corners
        step(32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 0, 2'b01, 32'h0300_8000, 0, 1);
        step(32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 0, 2'b01, 32'h0300_00FF, 0, 0);
        step(32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 0, 2'b01, 32'h0300_0100, 0, 0);
        // R6: modes off, subnormal and NaN untouched
        step(32'h0000_0003, 32'h7FFF_FFFF, 32'h0000_0007, 1, 2'b00, 32'hFCFF_FFFF, 1, 0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] c;
            c = $urandom & 32'h0000_9F00;
            if ($urandom_range(0, 1) == 0) c = 32'h0;
            c[24] = $urandom_range(0, 1);
            c[25] = $urandom_range(0, 1);
            step(gen_val(), gen_val(), gen_val(), $urandom_range(0, 1),
                 ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'b00,
                 c, $urandom_range(0, 3) != 0, $urandom_range(0, 15) == 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule